// File: doc/BRIEF.md
# DDR SDRAM Command Sequence Checker

This block watches the control pins of a DDR SDRAM channel at every rising clock edge. On each edge it works out which command the pins carry. The possible commands are mode register write, extended mode register write, auto refresh, self-refresh entry and exit, power-down entry and exit, activate, read, write, burst stop, precharge of one bank, precharge of all banks, no-operation, and clock-disabled hold. The block keeps a small model of the four banks. For each bank it knows whether a row is open, whether an auto-precharge is still in flight, and whether the precharge recovery time has run out.

When a command breaks a sequencing rule, the block raises a violation flag and a three-bit error code on the next output update. The block is meant to sit beside a memory controller, in simulation or on silicon, as a protocol monitor. A command that is flagged does not change the bank model. The model therefore keeps tracking the legal state, and one bad command does not cause a cascade of follow-on errors.

The burst length has a reset value set by a parameter. After that, it is taken from the low opcode bits of each legal mode register write. The precharge recovery count is a parameter.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, `viol` is 0, `viol_code` is 0, `cmd_seen` is 0 (NOP) and `bank_open` is 0000.
- R2: `cmd_seen` shows the command sampled at the previous edge, using these codes:
  - 0: NOP or deselect.
  - 1: MRS. RAS#/CAS#/WE# = LLL with BA0 low.
  - 2: EMRS. LLL with BA0 high.
  - 3: auto refresh. LLH.
  - 4: self-refresh entry. CKE falls with CS# low and LLH.
  - 5: self-refresh exit.
  - 6: power-down entry. Any other CKE fall.
  - 7: power-down exit. CKE rises while not in self refresh.
  - 8: activate. LHH.
  - 9: read. HLH.
  - 10: write. HLL.
  - 11: burst stop. HHL.
  - 12: single-bank precharge. LHL with A10 low.
  - 13: all-bank precharge. LHL with A10 high.
  - 14: hold. CKE low on both the previous and the current edge.
- R3: The bank number is BA1:BA0, and bank b is bit b of `bank_open`. An activate sets that bit. A precharge with A10 low clears only that bit.
- R4: A precharge with A10 high clears all four `bank_open` bits, whatever the value of BA.
- R5: An MRS or EMRS issued while any bank is open or has an auto-precharge pending gives code 1.
- R6: After a legal MRS or EMRS, any command at the very next edge other than NOP, deselect or hold gives code 2. This check has priority over every other rule.
- R7: An auto refresh or self-refresh entry issued while any bank is open or has an auto-precharge pending gives code 3.
- R8: A read or write to a bank that is closed, or that has an auto-precharge pending, gives code 4.
- R9: An activate to a bank that already has an open row gives code 5.
- R10: A write with A10 high at edge t blocks every read and write at edges t+1 to t+BL/2-1 with code 6. A read or write at edge t+BL/2 is accepted.
- R11: The bank that was auto-precharged closes at edge t+BL/2. An activate to that bank before edge t+BL/2+TRP_CYCLES gives code 7. An activate at that edge is accepted.
- R12: An MRS with A2:A0 equal to 001, 010 or 011 sets the burst length to 2, 4 or 8. Any other value keeps the current burst length. An EMRS does not change the burst length.
- R13: A burst stop never raises a violation under any burst length, except for the R6 spacing rule.
- R14: A flagged command leaves `bank_open` unchanged, and `viol` is high exactly when `viol_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock enable sampled at the previous edge |
| cke | input | 1 | Clock enable at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10_ap | input | 1 | Auto-precharge / all-bank select |
| mr_bl | input | 3 | Address bits A2:A0, the burst length opcode |
| viol | output | 1 | Violation seen at the previous edge |
| viol_code | output | 3 | Error code of that violation, 0 when none |
| cmd_seen | output | 4 | Command decoded at the previous edge |
| bank_open | output | 4 | Open-row flag for each bank |

## Verification
Every result is registered once. The command, the error code and the bank flags all appear just after the edge that sampled the pins, so the bench drives pins on the falling edge and checks two nanoseconds after the next rising edge.

The auto-precharge windows are counted in edges from the write. With burst length 8, reads and writes at edges t+1 to t+3 are expected to carry code 6, and the one at t+4 to pass. The bank closes at that same edge, and activates are refused until t+7. The same walk is repeated at burst lengths 2 and 4.

// File: rtl/ddrmon_pkg.sv
`timescale 1ns/1ps
package ddrmon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_MRS     = 4'd1,
        CMD_EMRS    = 4'd2,
        CMD_AREF    = 4'd3,
        CMD_SREF_IN = 4'd4,
        CMD_SREF_EX = 4'd5,
        CMD_PD_IN   = 4'd6,
        CMD_PD_EX   = 4'd7,
        CMD_ACT     = 4'd8,
        CMD_RD      = 4'd9,
        CMD_WR      = 4'd10,
        CMD_BST     = 4'd11,
        CMD_PRE     = 4'd12,
        CMD_PREA    = 4'd13,
        CMD_HOLD    = 4'd14
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_MRS_BUSY  = 3'd1,
        ERR_MRS_GAP   = 3'd2,
        ERR_REF_BUSY  = 3'd3,
        ERR_RW_CLOSED = 3'd4,
        ERR_ACT_OPEN  = 3'd5,
        ERR_AP_LOCK   = 3'd6,
        ERR_ACT_TRP   = 3'd7
    } err_e;

    localparam int NUM_BANKS = 4;
    localparam int BH_W      = 3;

    typedef struct packed {
        cmd_e             cmd;
        err_e             err;
        logic             viol;
        logic [BH_W-1:0]  bl_half;
        logic             mrs_gap;
        logic             in_sref;
    } mon_st_t;

endpackage

// File: rtl/ddrmon_decode.sv
`timescale 1ns/1ps
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       ba0,
    input  logic       a10_ap,
    input  logic       in_sref,
    output cmd_e       cmd
);
    logic [2:0] rcw;
    logic       is_ref;

    assign rcw    = {ras_n, cas_n, we_n};
    assign is_ref = !cs_n && (rcw == 3'b001);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev && !cke) begin
            cmd = CMD_HOLD;
        end else if (!cke_prev && cke) begin
            cmd = in_sref ? CMD_SREF_EX : CMD_PD_EX;
        end else if (cke_prev && !cke) begin
            cmd = is_ref ? CMD_SREF_IN : CMD_PD_IN;
        end else if (!cs_n) begin
            case (rcw)
                3'b000:  cmd = ba0 ? CMD_EMRS : CMD_MRS;
                3'b001:  cmd = CMD_AREF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = a10_ap ? CMD_PREA : CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrmon_bank.sv
`timescale 1ns/1ps
module ddrmon_bank
    import ddrmon_pkg::*;
#(
    parameter int TRP_CYCLES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act_i,
    input  logic            pre_i,
    input  logic            rw_i,
    input  logic            ap_i,
    input  logic            wr_i,
    input  logic [BH_W-1:0] bl_half_i,
    output logic            open_o,
    output logic            pend_o,
    output logic            lock_o,
    output logic            trp_busy_o
);
    localparam int TW = $clog2(TRP_CYCLES) + 1;

    typedef struct packed {
        logic            open;
        logic            pend;
        logic            pend_wr;
        logic [BH_W-1:0] cnt;
        logic [TW-1:0]   trp;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     burst_end;

    assign burst_end = st_q.pend && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (burst_end) begin
            st_d.pend    = 1'b0;
            st_d.pend_wr = 1'b0;
            st_d.open    = 1'b0;
            st_d.trp     = TW'(TRP_CYCLES - 1);
        end else begin
            if (st_q.pend) st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.trp != '0) st_d.trp = st_q.trp - 1'b1;
        end
        if (act_i) st_d.open = 1'b1;
        if (pre_i) st_d.open = 1'b0;
        if (rw_i && ap_i) begin
            st_d.pend    = 1'b1;
            st_d.pend_wr = wr_i;
            st_d.cnt     = bl_half_i - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o     = st_q.open;
    assign pend_o     = st_q.pend;
    assign lock_o     = st_q.pend && st_q.pend_wr && (st_q.cnt != '0);
    assign trp_busy_o = st_q.pend || (st_q.trp != '0);
endmodule

// File: rtl/ddr_cmd_monitor.sv
`timescale 1ns/1ps
module ddr_cmd_monitor
    import ddrmon_pkg::*;
#(
    parameter int BURST_LEN  = 4,
    parameter int TRP_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10_ap,
    input  logic [2:0] mr_bl,
    output logic       viol,
    output logic [2:0] viol_code,
    output logic [3:0] cmd_seen,
    output logic [3:0] bank_open
);
    localparam logic [BH_W-1:0] BH_RESET = BH_W'(BURST_LEN / 2);

    mon_st_t st_d, st_q;
    cmd_e    cmd;
    err_e    err;

    logic [NUM_BANKS-1:0] b_open, b_pend, b_lock, b_trp;
    logic [NUM_BANKS-1:0] act_v, pre_v, rw_v;
    logic [NUM_BANKS-1:0] sel;
    logic                 idle;

    ddrmon_decode u_dec (
        .cke_prev (cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba0      (ba[0]),
        .a10_ap   (a10_ap),
        .in_sref  (st_q.in_sref),
        .cmd      (cmd)
    );

    assign sel  = NUM_BANKS'(1) << ba;
    assign idle = (b_open == '0) && (b_pend == '0);

    always_comb begin
        err = ERR_NONE;
        if (st_q.mrs_gap && !(cmd inside {CMD_NOP, CMD_HOLD})) begin
            err = ERR_MRS_GAP;
        end else begin
            case (cmd)
                CMD_MRS, CMD_EMRS:
                    if (!idle) err = ERR_MRS_BUSY;
                CMD_AREF, CMD_SREF_IN:
                    if (!idle) err = ERR_REF_BUSY;
                CMD_ACT:
                    if ((b_trp & sel) != '0)       err = ERR_ACT_TRP;
                    else if ((b_open & sel) != '0) err = ERR_ACT_OPEN;
                CMD_RD, CMD_WR:
                    if (b_lock != '0)                                err = ERR_AP_LOCK;
                    else if (((b_open & ~b_pend) & sel) == '0)       err = ERR_RW_CLOSED;
                default: err = ERR_NONE;
            endcase
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.cmd     = cmd;
        st_d.err     = err;
        st_d.viol    = (err != ERR_NONE);
        st_d.mrs_gap = 1'b0;
        act_v        = '0;
        pre_v        = '0;
        rw_v         = '0;
        if (err == ERR_NONE) begin
            case (cmd)
                CMD_ACT:  act_v = sel;
                CMD_PRE:  pre_v = sel;
                CMD_PREA: pre_v = '1;
                CMD_RD, CMD_WR: rw_v = sel;
                CMD_MRS: begin
                    st_d.mrs_gap = 1'b1;
                    case (mr_bl)
                        3'b001:  st_d.bl_half = BH_W'(1);
                        3'b010:  st_d.bl_half = BH_W'(2);
                        3'b011:  st_d.bl_half = BH_W'(4);
                        default: st_d.bl_half = st_q.bl_half;
                    endcase
                end
                CMD_EMRS:    st_d.mrs_gap = 1'b1;
                CMD_SREF_IN: st_d.in_sref = 1'b1;
                CMD_SREF_EX: st_d.in_sref = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cmd     <= CMD_NOP;
            st_q.err     <= ERR_NONE;
            st_q.bl_half <= BH_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ddrmon_bank #(.TRP_CYCLES(TRP_CYCLES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_v[g]),
            .pre_i      (pre_v[g]),
            .rw_i       (rw_v[g]),
            .ap_i       (a10_ap),
            .wr_i       (cmd == CMD_WR),
            .bl_half_i  (st_q.bl_half),
            .open_o     (b_open[g]),
            .pend_o     (b_pend[g]),
            .lock_o     (b_lock[g]),
            .trp_busy_o (b_trp[g])
        );
    end

    assign viol      = st_q.viol;
    assign viol_code = st_q.err;
    assign cmd_seen  = st_q.cmd;
    assign bank_open = b_open;
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke_prev,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [1:0] ba,
    input logic       a10_ap,
    input logic [2:0] mr_bl,
    input logic       viol,
    input logic [2:0] viol_code,
    input logic [3:0] cmd_seen,
    input logic [3:0] bank_open
);
    logic live, is_act, is_rw, is_pre, is_bst;

    assign live   = cke_prev && cke && !cs_n;
    assign is_act = live && !ras_n && cas_n && we_n;
    assign is_rw  = live && ras_n && !cas_n;
    assign is_pre = live && !ras_n && cas_n && !we_n;
    assign is_bst = live && ras_n && cas_n && !we_n && (mr_bl == mr_bl);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!viol && viol_code == 3'd0 && bank_open == 4'd0));

    // R14
    flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol == (viol_code != 3'd0));

    // R9
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open[ba]) |=> viol);

    // R8
    rw_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !bank_open[ba]) |=> viol);

    // R3
    act_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && !bank_open[ba]) |=> (viol || bank_open[$past(ba)]));

    // R4
    prea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10_ap) |=> (bank_open == 4'd0));

    // R13
    bst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bst && cmd_seen != 4'd1 && cmd_seen != 4'd2) |=> !viol);
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_prev  (cke_prev),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .a10_ap    (a10_ap),
    .mr_bl     (mr_bl),
    .viol      (viol),
    .viol_code (viol_code),
    .cmd_seen  (cmd_seen),
    .bank_open (bank_open)
);

// File: tb/ddr_cmd_monitor_test.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'b00;
    logic       a10_ap = 1'b0;
    logic [2:0] mr_bl = 3'b000;
    logic       viol;
    logic [2:0] viol_code;
    logic [3:0] cmd_seen;
    logic [3:0] bank_open;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ddr_cmd_monitor #(.BURST_LEN(4), .TRP_CYCLES(3)) uut (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10_ap(a10_ap),
        .mr_bl(mr_bl), .viol(viol), .viol_code(viol_code), .cmd_seen(cmd_seen),
        .bank_open(bank_open)
    );

    // fields: cp ck cs | rcw | ba | ap | bl | exp cmd | exp code | exp open
    localparam int NV = 27;
    localparam logic [22:0] VEC [NV] = '{
        {3'b110, 3'b111, 2'b00, 1'b0, 3'b000, 4'd0,  3'd0, 4'b0000}, // R2 nop
        {3'b110, 3'b000, 2'b00, 1'b0, 3'b011, 4'd1,  3'd0, 4'b0000}, // R12 mrs bl8
        {3'b110, 3'b011, 2'b01, 1'b0, 3'b000, 4'd8,  3'd2, 4'b0000}, // R6 R14
        {3'b110, 3'b111, 2'b00, 1'b0, 3'b000, 4'd0,  3'd0, 4'b0000},
        {3'b110, 3'b011, 2'b01, 1'b0, 3'b000, 4'd8,  3'd0, 4'b0010}, // R3
        {3'b110, 3'b011, 2'b01, 1'b0, 3'b000, 4'd8,  3'd5, 4'b0010}, // R9
        {3'b110, 3'b101, 2'b00, 1'b0, 3'b000, 4'd9,  3'd4, 4'b0010}, // R8
        {3'b110, 3'b101, 2'b01, 1'b0, 3'b000, 4'd9,  3'd0, 4'b0010},
        {3'b110, 3'b000, 2'b01, 1'b0, 3'b000, 4'd2,  3'd1, 4'b0010}, // R5
        {3'b110, 3'b001, 2'b00, 1'b0, 3'b000, 4'd3,  3'd3, 4'b0010}, // R7
        {3'b100, 3'b001, 2'b00, 1'b0, 3'b000, 4'd4,  3'd3, 4'b0010}, // R7
        {3'b011, 3'b111, 2'b00, 1'b0, 3'b000, 4'd7,  3'd0, 4'b0010},
        {3'b110, 3'b011, 2'b11, 1'b0, 3'b000, 4'd8,  3'd0, 4'b1010}, // R3
        {3'b110, 3'b010, 2'b01, 1'b0, 3'b000, 4'd12, 3'd0, 4'b1000}, // R3
        {3'b110, 3'b010, 2'b00, 1'b1, 3'b000, 4'd13, 3'd0, 4'b0000}, // R4
        {3'b110, 3'b110, 2'b00, 1'b0, 3'b000, 4'd11, 3'd0, 4'b0000}, // R13
        {3'b110, 3'b100, 2'b10, 1'b0, 3'b000, 4'd10, 3'd4, 4'b0000}, // R8
        {3'b111, 3'b000, 2'b00, 1'b0, 3'b000, 4'd0,  3'd0, 4'b0000},
        {3'b101, 3'b111, 2'b00, 1'b0, 3'b000, 4'd6,  3'd0, 4'b0000},
        {3'b001, 3'b111, 2'b00, 1'b0, 3'b000, 4'd14, 3'd0, 4'b0000},
        {3'b011, 3'b111, 2'b00, 1'b0, 3'b000, 4'd7,  3'd0, 4'b0000},
        {3'b110, 3'b001, 2'b00, 1'b0, 3'b000, 4'd3,  3'd0, 4'b0000},
        {3'b100, 3'b001, 2'b00, 1'b0, 3'b000, 4'd4,  3'd0, 4'b0000},
        {3'b011, 3'b111, 2'b00, 1'b0, 3'b000, 4'd5,  3'd0, 4'b0000},
        {3'b110, 3'b000, 2'b01, 1'b0, 3'b000, 4'd2,  3'd0, 4'b0000},
        {3'b110, 3'b111, 2'b00, 1'b0, 3'b000, 4'd0,  3'd0, 4'b0000}, // R6 nop ok
        {3'b110, 3'b110, 2'b00, 1'b0, 3'b000, 4'd11, 3'd0, 4'b0000}
    };

    task automatic drive(input logic [2:0] ctl, input logic [2:0] rcw,
                         input logic [1:0] b, input logic ap, input logic [2:0] bl);
        @(negedge clk);
        {cke_prev, cke, cs_n} = ctl;
        {ras_n, cas_n, we_n}  = rcw;
        ba = b; a10_ap = ap; mr_bl = bl;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string rid, input logic [2:0] ecode, input logic [3:0] eopen);
        n_run++;
        if (viol !== (ecode != 3'd0) || viol_code !== ecode || bank_open !== eopen) begin
            n_fail++;
            $display("FAIL %s: viol=%0b code=%0d open=%b expected viol=%0b code=%0d open=%b",
                     rid, viol, viol_code, bank_open, (ecode != 3'd0), ecode, eopen);
        end
    endtask

    task automatic nop();                         drive(3'b110, 3'b111, 2'b00, 1'b0, 3'b000); endtask
    task automatic act(input logic [1:0] b);      drive(3'b110, 3'b011, b, 1'b0, 3'b000); endtask
    task automatic rd(input logic [1:0] b);       drive(3'b110, 3'b101, b, 1'b0, 3'b000); endtask
    task automatic wr(input logic [1:0] b, input logic ap); drive(3'b110, 3'b100, b, ap, 3'b000); endtask
    task automatic prea();                        drive(3'b110, 3'b010, 2'b00, 1'b1, 3'b000); endtask
    task automatic mrs(input logic [2:0] bl);     drive(3'b110, 3'b000, 2'b00, 1'b0, bl); endtask
    task automatic bst();                         drive(3'b110, 3'b110, 2'b00, 1'b0, 3'b000); endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog (all R): actual=timeout expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cs_n = 1'b1;
        #5;
        n_run++;
        if (viol !== 1'b0 || viol_code !== 3'd0 || cmd_seen !== 4'd0 || bank_open !== 4'd0) begin
            n_fail++;
            $display("FAIL R1 in reset: viol=%0b code=%0d cmd=%0d open=%b expected 0 0 0 0000",
                     viol, viol_code, cmd_seen, bank_open);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and table-driven sequencing checks
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][22:20], VEC[i][19:17], VEC[i][16:15], VEC[i][14], VEC[i][13:11]);
            chk($sformatf("R2/R14 vec%0d", i), VEC[i][6:4], VEC[i][3:0]);
            n_run++;
            if (cmd_seen !== VEC[i][10:7]) begin
                n_fail++;
                $display("FAIL R2 vec%0d: cmd=%0d expected %0d", i, cmd_seen, VEC[i][10:7]);
            end
        end

        // R10 R11 burst length 8: write with auto precharge on bank 0
        act(2'b00); chk("R3 act A", 3'd0, 4'b0001);
        act(2'b01); chk("R3 act B", 3'd0, 4'b0011);
        wr(2'b00, 1'b1); chk("R10 wr-ap A", 3'd0, 4'b0011);
        rd(2'b01); chk("R10 lock t+1", 3'd6, 4'b0011);
        wr(2'b01, 1'b0); chk("R10 lock t+2", 3'd6, 4'b0011);
        nop();     chk("R10 t+3 nop", 3'd0, 4'b0011);
        rd(2'b01); chk("R10 free t+4 / R11 close", 3'd0, 4'b0010);
        act(2'b00); chk("R11 trp t+5", 3'd7, 4'b0010);
        act(2'b00); chk("R11 trp t+6", 3'd7, 4'b0010);
        act(2'b00); chk("R11 trp done t+7", 3'd0, 4'b0011);

        // R12 burst length 2
        prea(); chk("R4 prea", 3'd0, 4'b0000);
        mrs(3'b001); chk("R12 mrs bl2", 3'd0, 4'b0000);
        nop(); bst(); chk("R13 bst bl2", 3'd0, 4'b0000);
        act(2'b00); chk("R3 act A bl2", 3'd0, 4'b0001);
        wr(2'b00, 1'b1); chk("R10 wr-ap bl2", 3'd0, 4'b0001);
        act(2'b01); chk("R11 close t+1 bl2", 3'd0, 4'b0010);
        act(2'b00); chk("R11 trp bl2 t+2", 3'd7, 4'b0010);
        act(2'b00); chk("R11 trp bl2 t+3", 3'd7, 4'b0010);
        act(2'b00); chk("R11 trp bl2 t+4", 3'd0, 4'b0011);

        // R12 burst length 4, then an unused opcode keeps it
        prea(); chk("R4 prea 2", 3'd0, 4'b0000);
        mrs(3'b010); chk("R12 mrs bl4", 3'd0, 4'b0000);
        nop();
        mrs(3'b111); chk("R12 mrs bad code", 3'd0, 4'b0000);
        nop();
        bst(); chk("R13 bst bl4", 3'd0, 4'b0000);
        act(2'b00); act(2'b01); chk("R3 act A B bl4", 3'd0, 4'b0011);
        wr(2'b00, 1'b1); chk("R10 wr-ap bl4", 3'd0, 4'b0011);
        rd(2'b01); chk("R10 lock bl4 t+1", 3'd6, 4'b0011);
        rd(2'b01); chk("R12 kept bl4 free t+2", 3'd0, 4'b0010);
        rd(2'b00); chk("R8 rd closed after ap", 3'd4, 4'b0010);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        n_run++;
        if (viol !== 1'b0 || viol_code !== 3'd0 || cmd_seen !== 4'd0 || bank_open !== 4'd0) begin
            n_fail++;
            $display("FAIL R1 mid reset: viol=%0b code=%0d cmd=%0d open=%b expected 0 0 0 0000",
                     viol, viol_code, cmd_seen, bank_open);
        end
        @(negedge clk);
        rst_n = 1'b1;
        nop(); chk("R1 after release", 3'd0, 4'b0000);
        rd(2'b10); chk("R8 rd after reset", 3'd4, 4'b0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule